// File: doc/BRIEF.md
# SPI Slave Fan-Out Selector

This block lets an SPI master with only one chip select line reach up to eight slaves. It watches the master's clock, data-out line and chip select. It treats the first byte of every transfer as an in-band target number, and no slave ever sees that byte. The slave output clock stays low for the whole of that byte. After the byte has been received, the block pulls the chosen slave's select low and passes the master clock through to the slaves. The passed clock starts on the first rising edge of the second byte and stays in step with the input clock. The master's data lines are wired straight to the slaves, so payload bytes never go through this block.

One extra target number, equal to the slave count, selects a one-byte settings register inside the block instead of a slave. During the byte that follows the target number, the block shifts the register's current contents out to the master. At the end of that same byte it stores what the master sent. Target numbers above that value are invalid: they select nothing and leave the slave clock idle until the master releases its chip select. All logic runs on the SPI clock in mode 0 (clock idle low, data sampled on the rising edge). The master chip select is sampled as a synchronous input. Its release also clears the target immediately at the outputs.

Top module: `spi_fan_mux`

## Requirements
- R1: After reset all slave selects are high (inactive), the slave clock is low, the readback enable is low, and the settings register holds 8'h3C.
- R2: The first 8 bits after the chip select falls are taken MSB first as the target number. During those 8 bit times no slave select goes low and the slave clock stays low.
- R3: For a target number t below 8, only slave select t goes low, right after the 8th rising edge, and it stays low until the chip select rises.
- R4: For a slave target, the slave clock copies the input clock from the first rising edge of the second byte until the chip select rises.
- R5: For target number 8, no slave select goes low and the slave clock stays low. During the second byte the readback enable is high, and the readback line carries the settings register MSB first, one bit per bit time.
- R6: For target number 8, the second byte (MSB first) is written into the settings register at its 8th rising edge. The new value is returned by the next readback.
- R7: For target numbers 9 to 255, no slave select goes low, the slave clock stays low and the readback enable stays low for the whole transfer, and the settings register keeps its value.
- R8: When the chip select rises, all slave selects go high and the slave clock goes low. This holds even in the middle of the address byte, and the next fall of the chip select starts a fresh address byte.
- R9: For target number 8, bytes after the second do not write the settings register and leave the readback enable low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | SPI clock from the master, rising edge active |
| rst_i | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Master chip select, active low |
| mosi_i | input | 1 | Master data out, observed only |
| sclk_o | output | 1 | Gated clock to the slaves, idle low |
| ss_n_o | output | NUM_SLAVES | Per-slave select, active low |
| miso_o | output | 1 | Readback bit of the settings register |
| miso_oe_o | output | 1 | High while the readback bit is driven onto the shared MISO line |

## Verification
A bit counter that is off by one shows up within the same transfer. The select then goes low one bit time early or late, the clock gate opens on the wrong edge, and the captured target number is shifted, so the wrong slave select falls or none does. A phase flag that does not clear on chip-select release shows up at the very next transfer as a slave clock pulse inside its address byte. A write to the settings register at the wrong time stays hidden until the next readback through target 8, which then returns the wrong byte.

// File: rtl/spi_fan_pkg.sv
package spi_fan_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  bitcnt_t;

    typedef enum logic {
        PH_ADDR = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    typedef enum logic [1:0] {
        TGT_SLAVE = 2'd0,
        TGT_CFG   = 2'd1,
        TGT_BAD   = 2'd2
    } target_e;

    typedef struct packed {
        phase_e  phase;
        bitcnt_t bit_cnt;
        logic    first_data;
        logic    byte_done;
        byte_t   addr;
        byte_t   byte_now;
    } rx_state_t;

    function automatic target_e classify(input byte_t a, input int n_slaves);
        if (int'(a) < n_slaves)       return TGT_SLAVE;
        else if (int'(a) == n_slaves) return TGT_CFG;
        else                          return TGT_BAD;
    endfunction

endpackage

// File: rtl/spi_fan_addr_rx.sv
module spi_fan_addr_rx
    import spi_fan_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      cs_n_i,
    input  logic      mosi_i,
    output rx_state_t st_o
);
    phase_e  phase_q;
    bitcnt_t cnt_q;
    logic    first_q;
    byte_t   shift_q;
    byte_t   addr_q;
    logic    last_bit;
    byte_t   byte_now;

    assign last_bit = (cnt_q == bitcnt_t'(BYTE_W - 1));
    assign byte_now = {shift_q[BYTE_W-2:0], mosi_i};

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            addr_q <= '0;
        end else if (!cs_n_i && phase_q == PH_ADDR && last_bit) begin
            addr_q <= byte_now;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || cs_n_i) begin
            phase_q <= PH_ADDR;
            cnt_q   <= '0;
            first_q <= 1'b1;
            shift_q <= '0;
        end else begin
            shift_q <= byte_now;
            cnt_q   <= cnt_q + 1'b1;
            if (last_bit) begin
                if (phase_q == PH_ADDR) phase_q <= PH_DATA;
                else                    first_q <= 1'b0;
            end
        end
    end

    assign st_o = '{phase: phase_q, bit_cnt: cnt_q, first_data: first_q,
                    byte_done: last_bit, addr: addr_q, byte_now: byte_now};

    // R2
    addr_phase_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_q == PH_ADDR && !last_bit) |=> (phase_q == PH_ADDR));

    // R8
    cs_release_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        cs_n_i |=> (phase_q == PH_ADDR && cnt_q == '0 && first_q));
endmodule

// File: rtl/spi_fan_decode.sv
module spi_fan_decode
    import spi_fan_pkg::*;
#(
    parameter int NUM_SLAVES = 8
) (
    input  logic                  active_i,
    input  byte_t                 addr_i,
    output target_e               kind_o,
    output logic [NUM_SLAVES-1:0] ss_n_o
);
    assign kind_o = classify(addr_i, NUM_SLAVES);

    for (genvar g = 0; g < NUM_SLAVES; g++) begin : g_sel
        assign ss_n_o[g] = ~(active_i && (kind_o == TGT_SLAVE) &&
                             (addr_i == byte_t'(g)));
    end
endmodule

// File: rtl/spi_fan_clk_gate.sv
module spi_fan_clk_gate (
    input  logic clk_i,
    input  logic rst_i,
    input  logic cs_n_i,
    input  logic en_i,
    output logic gate_o,
    output logic sclk_o
);
    logic gate_q;

    // enable changes only while the clock is low, so no pulse is clipped
    always_ff @(negedge clk_i) begin
        if (rst_i) gate_q <= 1'b0;
        else       gate_q <= en_i;
    end

    assign gate_o = gate_q;
    assign sclk_o = clk_i & gate_q & ~cs_n_i;
endmodule

// File: rtl/spi_fan_cfg.sv
module spi_fan_cfg
    import spi_fan_pkg::*;
#(
    parameter byte_t CFG_RESET = 8'h3C
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      sel_i,
    input  rx_state_t st_i,
    output byte_t     cfg_o,
    output logic      miso_o,
    output logic      miso_oe_o
);
    byte_t   cfg_q;
    logic    wr_en;
    bitcnt_t rd_idx;

    assign wr_en     = sel_i && st_i.first_data && st_i.byte_done;
    assign rd_idx    = bitcnt_t'(BYTE_W - 1) - st_i.bit_cnt;
    assign miso_o    = cfg_q[rd_idx];
    assign miso_oe_o = sel_i && st_i.first_data;
    assign cfg_o     = cfg_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)      cfg_q <= CFG_RESET;
        else if (wr_en) cfg_q <= st_i.byte_now;
    end

    // R6
    cfg_write_window_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(cfg_q) |-> ($past(wr_en) || $past(rst_i)));
endmodule

// File: rtl/spi_fan_mux.sv
module spi_fan_mux
    import spi_fan_pkg::*;
#(
    parameter int    NUM_SLAVES = 8,
    parameter byte_t CFG_RESET  = 8'h3C
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  cs_n_i,
    input  logic                  mosi_i,
    output logic                  sclk_o,
    output logic [NUM_SLAVES-1:0] ss_n_o,
    output logic                  miso_o,
    output logic                  miso_oe_o
);
    rx_state_t st;
    target_e   kind;
    logic      active;
    logic      cfg_sel;
    logic      gate;
    byte_t     cfg_val;

    spi_fan_addr_rx u_rx (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .cs_n_i (cs_n_i),
        .mosi_i (mosi_i),
        .st_o   (st)
    );

    assign active = (st.phase == PH_DATA) && !cs_n_i;

    spi_fan_decode #(.NUM_SLAVES(NUM_SLAVES)) u_dec (
        .active_i (active),
        .addr_i   (st.addr),
        .kind_o   (kind),
        .ss_n_o   (ss_n_o)
    );

    assign cfg_sel = active && (kind == TGT_CFG);

    spi_fan_clk_gate u_gate (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .cs_n_i (cs_n_i),
        .en_i   (active && (kind == TGT_SLAVE)),
        .gate_o (gate),
        .sclk_o (sclk_o)
    );

    spi_fan_cfg #(.CFG_RESET(CFG_RESET)) u_cfg (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .sel_i     (cfg_sel),
        .st_i      (st),
        .cfg_o     (cfg_val),
        .miso_o    (miso_o),
        .miso_oe_o (miso_oe_o)
    );

    // R3
    one_select_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(~ss_n_o));

    // R8
    release_selects_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        cs_n_i |-> (&ss_n_o));

    // R2
    no_gate_in_addr_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (st.phase == PH_ADDR) |-> !gate);

    // R5
    readback_no_slave_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        miso_oe_o |-> ((&ss_n_o) && !gate));

    // R7
    bad_target_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (active && kind == TGT_BAD) |-> ((&ss_n_o) && !miso_oe_o && $stable(cfg_val)));
endmodule

// File: tb/spi_fan_mux_test.sv
module spi_fan_mux_test;
    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_n = 1'b1;
    logic          mosi = 1'b0;
    logic          sclk;
    logic [NS-1:0] ss_n;
    logic          miso;
    logic          miso_oe;

    int   checks = 0;
    int   errors = 0;
    logic [7:0] cfg_model = 8'h3C;

    always #5 clk = ~clk;

    spi_fan_mux #(.NUM_SLAVES(NS), .CFG_RESET(8'h3C)) uut (
        .clk_i     (clk),
        .rst_i     (rst),
        .cs_n_i    (cs_n),
        .mosi_i    (mosi),
        .sclk_o    (sclk),
        .ss_n_o    (ss_n),
        .miso_o    (miso),
        .miso_oe_o (miso_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [NS-1:0] exp_ss(input logic [7:0] a);
        logic [NS-1:0] v = '1;
        if (int'(a) < NS) v[a[2:0]] = 1'b0;
        return v;
    endfunction

    // one bit time: drive at the falling edge, sample before and after the rising edge
    task automatic bit_time(input logic b, input bit start, output logic sck,
                            output logic so, output logic soe, output logic [NS-1:0] ss);
        @(negedge clk);
        if (start) cs_n = 1'b0;
        mosi = b;
        #1;
        so = miso; soe = miso_oe; ss = ss_n;
        @(posedge clk);
        #1;
        sck = sclk;
    endtask

    task automatic end_xfer();
        @(negedge clk);
        cs_n = 1'b1;
        #1;
        chk(&ss_n, "R8 selects released", ss_n, '1);
        @(posedge clk);
        #1;
        chk(sclk == 1'b0 && &ss_n, "R8 clock idle after release", {sclk, ss_n}, {1'b0, {NS{1'b1}}});
        @(negedge clk);
    endtask

    // addr byte, then nbytes data bytes; abort_bits>0 ends the transfer early
    task automatic xfer(input logic [7:0] addr, input int nbytes, input logic [23:0] data,
                        input int abort_bits);
        logic sck, so, soe;
        logic [NS-1:0] ss;
        bit addr_bad = 1'b0;
        logic [7:0] rd = '0;
        bit slave = int'(addr) < NS;
        bit cfg   = int'(addr) == NS;
        int nb    = (abort_bits > 0) ? abort_bits : 8;
        for (int i = 0; i < nb; i++) begin
            bit_time(addr[7-i], i == 0, sck, so, soe, ss);
            if (sck !== 1'b0 || ss !== '1 || soe !== 1'b0) addr_bad = 1'b1;
        end
        chk(!addr_bad, "R2 address byte hidden", addr_bad, 0);
        if (abort_bits == 0) begin
            for (int k = 0; k < nbytes; k++) begin
                logic [7:0] d = data[23-8*k -: 8];
                for (int j = 0; j < 8; j++) begin
                    bit_time(d[7-j], 1'b0, sck, so, soe, ss);
                    if (slave) begin
                        chk(ss == exp_ss(addr), "R3 slave select", ss, exp_ss(addr));
                        chk(sck == 1'b1, "R4 slave clock passes", sck, 1);
                    end else begin
                        chk(ss == '1, cfg ? "R5 no select for cfg" : "R7 no select",
                            ss, '1);
                        chk(sck == 1'b0, cfg ? "R5 clock idle" : "R7 clock idle", sck, 0);
                    end
                    if (cfg && k == 0) begin
                        chk(soe == 1'b1, "R5 readback enable", soe, 1);
                        rd[7-j] = so;
                    end else begin
                        chk(soe == 1'b0, cfg ? "R9 no readback later" : "R7 no readback",
                            soe, 0);
                    end
                end
                if (cfg && k == 0) begin
                    chk(rd == cfg_model, "R5 R6 readback value", rd, cfg_model);
                    cfg_model = d;
                end
            end
        end
        end_xfer();
    endtask

    initial begin
        int unused;
        unused = $urandom(32'd1234);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(&ss_n, "R1 selects after reset", ss_n, '1);
        chk(miso_oe == 1'b0, "R1 readback off after reset", miso_oe, 0);
        @(posedge clk); #1;
        chk(sclk == 1'b0, "R1 clock idle after reset", sclk, 0);

        xfer(8'd8, 1, 24'h5A0000, 0);        // R1 reset value read, R6 write
        xfer(8'd8, 2, 24'hC37700, 0);        // R6 and R9
        xfer(8'd9, 2, 24'hFFFF00, 0);        // R7
        xfer(8'd255, 1, 24'h000000, 0);      // R7
        xfer(8'd8, 1, 24'h960000, 0);        // R7 cfg kept C3
        xfer(8'd0, 2, 24'hA5A500, 0);        // R3 R4
        xfer(8'd7, 3, 24'h123456, 0);        // R3 R4
        xfer(8'h60, 1, 24'h110000, 0);       // R2 MSB first: 0x60 is invalid
        xfer(8'h06, 1, 24'h220000, 0);       // R2 MSB first: slave 6
        xfer(8'd3, 0, 24'h0, 4);             // R8 abort mid address
        xfer(8'd3, 1, 24'hEE0000, 0);        // R8 fresh address phase
        xfer(8'd8, 0, 24'h0, 3);             // R8 abort, cfg untouched

        for (int n = 0; n < 60; n++) begin
            logic [7:0] a;
            int r = $urandom_range(0, 9);
            if (r < 6)       a = 8'($urandom_range(0, NS - 1));
            else if (r < 8)  a = 8'(NS);
            else             a = 8'($urandom_range(NS + 1, 255));
            xfer(a, $urandom_range(1, 3), 24'($urandom), 0);
        end
        xfer(8'd8, 1, 24'h0, 0);             // R6 final readback

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule